// File: doc/BRIEF.md
# Flux-Pulse Read Separator with Sync Detection

This block turns the stream of flux-transition pulses from a disk read amplifier into recovered serial bits, assembles them into bytes and flags sync marks. A small cell counter runs on a divided-clock enable whose rate is set elsewhere for the current zone. Every transition pulse clears the counter. The upper counter bits are NOR-ed together to form the bit value, which is sampled once per bit cell.

Recovered bits enter a shift register with the newest bit in the least significant position. A sync flag, active low, is asserted while the most recent eight bits are all ones. Byte framing is held in reset while sync is active, so the first 0 after a sync mark becomes the first bit of a byte. After every eighth framed bit, the shift register is copied into an output latch and a one-cycle byte-ready strobe is raised. The latch then holds its value until the next byte completes.

Top module: `flux_read_sep`

## Requirements
- R1: While reset is active and in the first cycle after it, `rx_byte` is 0, `byte_rdy` is 0, `sync_n` is 1 and `bit_stb` is 0.
- R2: A `flux_pulse` clears the cell counter to 0 and overrides a `cell_en` in the same cycle. No `bit_stb` occurs in a pulse cycle.
- R3: `bit_stb` is high, combinationally, in a cycle whose `cell_en` takes the counter to a value whose low two bits are 2. This is the second enable after a clear and then every fourth enable.
- R4: During `bit_stb`, `bit_val` is 1 when the counter's new value has bits 3 and 2 both zero, and 0 otherwise. The 4-bit counter wraps modulo 16, so a cell holding a transition reads as 1 and up to three following empty cells read as 0.
- R5: Bits are shifted in MSB first. In a completed byte, `rx_byte[7]` is the earliest bit and `rx_byte[0]` is the latest.
- R6: `sync_n` is 0 exactly while the last eight recovered bits are all 1. It falls in the cycle after the strobe of the eighth 1.
- R7: While the newly shifted word is all ones, the framing count is forced to zero. Framing restarts on the first 0 bit after a sync, and that bit becomes `rx_byte[7]`.
- R8: `byte_rdy` is a single-cycle pulse. It is high in the cycle after the strobe that completes the eighth framed bit, and that strobe must not produce sync.
- R9: `rx_byte` changes only in the cycle in which `byte_rdy` is high.
- R10: Without `cell_en`, no bit is strobed, whether or not pulses arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cell_en | input | 1 | Divided-clock enable that advances the cell counter |
| flux_pulse | input | 1 | Synchronous one-cycle flux transition pulse |
| bit_stb | output | 1 | Strobe marking a recovered bit this cycle |
| bit_val | output | 1 | Recovered bit value, valid with `bit_stb` |
| rx_byte | output | 8 | Latched received byte, MSB first |
| byte_rdy | output | 1 | One-cycle byte-complete strobe |
| sync_n | output | 1 | Active-low sync flag (last eight bits all ones) |

## Verification
A wrong counter value, such as a missed clear or a skipped enable, shows up at once on `bit_stb` or `bit_val` in the cycle of the next sampled enable. The reference model compares both signals every cycle. A corrupted shift register shows on `sync_n` in the following cycle, or on `rx_byte` at the next `byte_rdy`. A framing count that is off by one shows as a `byte_rdy` pulse in the wrong cycle, at most eight bit cells later. The directed sync-then-data sequence pins the framing restart to a known byte value.

// File: rtl/rsep_pkg.sv
package rsep_pkg;

   // Default geometry of the separator
   localparam int DEF_CNT_W    = 4;
   localparam int DEF_CELL_LOG = 2;
   localparam int DEF_BYTE_W   = 8;

   // One recovered bit event
   typedef struct packed {
      logic stb;
      logic val;
   } bit_evt_t;

endpackage

// File: rtl/rsep_cell_counter.sv
module rsep_cell_counter
   import rsep_pkg::*;
#(
   parameter int CNT_W    = DEF_CNT_W,
   parameter int CELL_LOG = DEF_CELL_LOG
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     cell_en,
   input  logic     flux_pulse,
   output bit_evt_t evt
);

   localparam int HI_W = CNT_W - CELL_LOG;
   localparam logic [CELL_LOG-1:0] SAMPLE_PH = CELL_LOG'(1 << (CELL_LOG - 1));

   generate
      if (CELL_LOG < 1) begin : g_bad_cell
         $error("rsep_cell_counter: CELL_LOG must be at least 1");
      end
      if (CNT_W <= CELL_LOG) begin : g_bad_cnt
         $error("rsep_cell_counter: CNT_W must exceed CELL_LOG");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_nxt;
   logic [HI_W:0]    hi_or;

   assign cnt_nxt = cnt_q + CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (flux_pulse) begin
         cnt_q <= '0;
      end else if (cell_en) begin
         cnt_q <= cnt_nxt;
      end
   end

   // NOR across the upper counter bits of the value being entered
   assign hi_or[0] = 1'b0;
   generate
      for (genvar i = 0; i < HI_W; i++) begin : g_hi_or
         assign hi_or[i+1] = hi_or[i] | cnt_nxt[CELL_LOG+i];
      end
   endgenerate

   assign evt.stb = cell_en & ~flux_pulse & (cnt_nxt[CELL_LOG-1:0] == SAMPLE_PH);
   assign evt.val = ~hi_or[HI_W];

   AST_STB_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      evt.stb |=> !evt.stb); // R3

   AST_PULSE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      flux_pulse |=> (cnt_q == '0)); // R2

endmodule

// File: rtl/rsep_shifter.sv
module rsep_shifter
   import rsep_pkg::*;
#(
   parameter int BYTE_W   = DEF_BYTE_W,
   parameter int SYNC_LEN = DEF_BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  bit_evt_t          evt,
   output logic [BYTE_W-1:0] word_nxt,
   output logic              sync_nxt,
   output logic              sync_n
);

   generate
      if (BYTE_W < 2) begin : g_bad_w
         $error("rsep_shifter: BYTE_W must be at least 2");
      end
      if (SYNC_LEN < 1 || SYNC_LEN > BYTE_W) begin : g_bad_sync
         $error("rsep_shifter: SYNC_LEN out of range");
      end
   endgenerate

   logic [BYTE_W-1:0] sreg_q;
   logic              sync_q;

   assign word_nxt = {sreg_q[BYTE_W-2:0], evt.val};

   // Sync window: whole register or its newest SYNC_LEN bits
   generate
      if (SYNC_LEN == BYTE_W) begin : g_sync_full
         assign sync_nxt = &word_nxt;
         assign sync_q   = &sreg_q;
      end else begin : g_sync_part
         assign sync_nxt = &word_nxt[SYNC_LEN-1:0];
         assign sync_q   = &sreg_q[SYNC_LEN-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg_q <= '0;
      end else if (evt.stb) begin
         sreg_q <= word_nxt;
      end
   end

   assign sync_n = ~sync_q;

   AST_SYNC_FROM_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sync_n) |-> $past(evt.stb && evt.val)); // R6

   AST_SYNC_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(evt.stb) |-> $stable(sync_n)); // R6

endmodule

// File: rtl/rsep_framer.sv
module rsep_framer
   import rsep_pkg::*;
#(
   parameter int BYTE_W = DEF_BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  bit_evt_t          evt,
   input  logic [BYTE_W-1:0] word_nxt,
   input  logic              sync_nxt,
   input  logic              sync_n,
   output logic [BYTE_W-1:0] rx_byte,
   output logic              byte_rdy
);

   localparam int CW = (BYTE_W > 2) ? $clog2(BYTE_W) : 1;
   localparam logic [CW-1:0] LAST = CW'(BYTE_W - 1);

   generate
      if (BYTE_W < 2) begin : g_bad_w
         $error("rsep_framer: BYTE_W must be at least 2");
      end
   endgenerate

   logic [CW-1:0] bitcnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bitcnt_q <= '0;
         rx_byte  <= '0;
         byte_rdy <= 1'b0;
      end else begin
         byte_rdy <= 1'b0;
         if (evt.stb) begin
            if (sync_nxt) begin
               bitcnt_q <= '0;
            end else if (bitcnt_q == LAST) begin
               bitcnt_q <= '0;
               rx_byte  <= word_nxt;
               byte_rdy <= 1'b1;
            end else begin
               bitcnt_q <= bitcnt_q + CW'(1);
            end
         end
      end
   end

   AST_RDY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      byte_rdy |=> !byte_rdy); // R8

   AST_RDY_AFTER_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      byte_rdy |-> $past(evt.stb)); // R8

   AST_BYTE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !byte_rdy |-> $stable(rx_byte)); // R9

   AST_SYNC_FRAME_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !sync_n |-> (bitcnt_q == '0)); // R7

endmodule

// File: rtl/flux_read_sep.sv
module flux_read_sep
   import rsep_pkg::*;
#(
   parameter int CNT_W    = DEF_CNT_W,
   parameter int CELL_LOG = DEF_CELL_LOG,
   parameter int BYTE_W   = DEF_BYTE_W,
   parameter int SYNC_LEN = DEF_BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cell_en,
   input  logic              flux_pulse,
   output logic              bit_stb,
   output logic              bit_val,
   output logic [BYTE_W-1:0] rx_byte,
   output logic              byte_rdy,
   output logic              sync_n
);

   bit_evt_t          evt;
   logic [BYTE_W-1:0] word_nxt;
   logic              sync_nxt;

   rsep_cell_counter #(
      .CNT_W    (CNT_W),
      .CELL_LOG (CELL_LOG)
   ) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .cell_en    (cell_en),
      .flux_pulse (flux_pulse),
      .evt        (evt)
   );

   rsep_shifter #(
      .BYTE_W   (BYTE_W),
      .SYNC_LEN (SYNC_LEN)
   ) u_shf (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (evt),
      .word_nxt (word_nxt),
      .sync_nxt (sync_nxt),
      .sync_n   (sync_n)
   );

   rsep_framer #(
      .BYTE_W (BYTE_W)
   ) u_frm (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (evt),
      .word_nxt (word_nxt),
      .sync_nxt (sync_nxt),
      .sync_n   (sync_n),
      .rx_byte  (rx_byte),
      .byte_rdy (byte_rdy)
   );

   assign bit_stb = evt.stb;
   assign bit_val = evt.val;

   AST_NO_STB_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !cell_en |-> !bit_stb); // R10

endmodule

// File: tb/flux_read_sep_tb.sv
module flux_read_sep_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cell_en = 1'b0;
   logic       flux_pulse = 1'b0;
   logic       bit_stb, bit_val, byte_rdy, sync_n;
   logic [7:0] rx_byte;

   always #2.5 clk = ~clk;

   flux_read_sep u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .cell_en    (cell_en),
      .flux_pulse (flux_pulse),
      .bit_stb    (bit_stb),
      .bit_val    (bit_val),
      .rx_byte    (rx_byte),
      .byte_rdy   (byte_rdy),
      .sync_n     (sync_n)
   );

   int    checks = 0;
   int    errors = 0;
   bit    done = 1'b0;
   string stb_tag = "R3";

   // Reference model state
   int         m_enc;     // enables since last clear
   logic [7:0] m_hist;    // recent bits, newest at bit 0
   int         m_nb;      // framed bits in current byte
   logic [7:0] m_byte;
   logic       m_rdy;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_enc = 0; m_hist = '0; m_nb = 0; m_byte = '0; m_rdy = 1'b0;
   endtask

   // One reference cycle: drive, compare at negedge, advance model
   task automatic step(input logic en, input logic pl);
      bit e_stb;
      bit e_val;
      int nxt;
      cell_en = en;
      flux_pulse = pl;
      nxt = m_enc + 1;
      e_stb = en && !pl && ((nxt % 4) == 2);
      e_val = ((nxt % 16) < 4);
      @(negedge clk);
      chk(bit_stb == e_stb, stb_tag, 32'(bit_stb), 32'(e_stb));
      if (e_stb) chk(bit_val == e_val, "R4", 32'(bit_val), 32'(e_val));
      chk(byte_rdy == m_rdy, "R8", 32'(byte_rdy), 32'(m_rdy));
      chk(rx_byte == m_byte, "R9", 32'(rx_byte), 32'(m_byte));
      chk(sync_n == !(&m_hist), "R6", 32'(sync_n), 32'(!(&m_hist)));
      m_rdy = 1'b0;
      if (pl) begin
         m_enc = 0;
      end else if (en) begin
         m_enc = nxt % 16;
         if (e_stb) begin
            m_hist = {m_hist[6:0], e_val};
            if (&m_hist) begin
               m_nb = 0;          // R7 framing held during sync
            end else begin
               m_nb++;
               if (m_nb == 8) begin
                  m_nb = 0;
                  m_byte = m_hist;
                  m_rdy = 1'b1;
               end
            end
         end
      end
      @(posedge clk);
      #1;
   endtask

   // One bit cell of four enables; a 1 carries a leading transition
   task automatic send_bit(input bit b);
      if (b) step(1'b0, 1'b1);
      repeat (4) begin
         step(1'b1, 1'b0);
         step(1'b0, 1'b0);
      end
   endtask

   task automatic send_byte(input logic [7:0] v);
      for (int i = 7; i >= 0; i--) send_bit(v[i]);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog act=%0d exp=%0d", 150000, 0);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      model_reset();
      repeat (4) @(posedge clk);
      #1;
      // R1: reset values held during reset
      chk(rx_byte == 8'h00, "R1", 32'(rx_byte), 32'h0);
      chk(byte_rdy == 1'b0, "R1", 32'(byte_rdy), 32'h0);
      chk(sync_n == 1'b1, "R1", 32'(sync_n), 32'h1);
      rst_n = 1'b1;
      @(negedge clk);
      chk(bit_stb == 1'b0, "R1", 32'(bit_stb), 32'h0);
      chk(sync_n == 1'b1, "R1", 32'(sync_n), 32'h1);
      @(posedge clk);
      #1;

      // R6 / R7: sync run of ones, then framed bytes
      repeat (10) send_bit(1'b1);
      chk(sync_n == 1'b0, "R6", 32'(sync_n), 32'h0);
      send_byte(8'h5A);
      chk(rx_byte == 8'h5A, "R7", 32'(rx_byte), 32'h5A);
      chk(sync_n == 1'b1, "R6", 32'(sync_n), 32'h1);
      send_byte(8'h6D);
      chk(rx_byte == 8'h6D, "R5", 32'(rx_byte), 32'h6D);
      send_byte(8'hB6);
      chk(rx_byte == 8'hB6, "R5", 32'(rx_byte), 32'hB6);

      // R10: pulses with no enable never strobe
      stb_tag = "R10";
      for (int i = 0; i < 40; i++) step(1'b0, (i % 3) == 0);

      // R2: pulse collides with enable, pulse wins
      stb_tag = "R2";
      for (int i = 0; i < 40; i++) step(1'b1, (i % 2) == 0);
      stb_tag = "R3";

      // R4: long gaps wrap the counter and yield spurious ones
      repeat (3) begin
         step(1'b0, 1'b1);
         repeat (40) step(1'b1, 1'b0);
      end

      // Random sparse and dense traffic
      for (int i = 0; i < 5000; i++)
         step(($urandom_range(0, 1) == 1), ($urandom_range(0, 11) == 0));
      for (int i = 0; i < 3000; i++)
         step(($urandom_range(0, 2) != 0), ($urandom_range(0, 4) == 0));

      // Another sync and byte after random traffic
      repeat (9) send_bit(1'b1);
      send_byte(8'h2B);
      chk(rx_byte == 8'h2B, "R7", 32'(rx_byte), 32'h2B);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule